// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer for a chip's register bus. A 16-bit counter counts down by one on every tick. The tick comes from a chain of two dividers on the system clock. The first divider is programmable and divides by P+1, where P is an 8-bit value. The second divider divides by 16, 32, 64 or 128. Software prevents expiry by writing a fresh value into the live counter before it runs out.

When a tick arrives and the counter has no time left, the block reloads the counter from a separate reload register and counts on. On that expiry it can produce one or both of two outputs, each with its own enable bit. The first is a one-cycle interrupt pulse. The second is a system reset request that stays high for a fixed number of clocks. Reads and writes complete in a single cycle. The read data is combinational from the address.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control word reads 0x8019: timer off, divider select 3, prescale 0x80, reset enable on, interrupt enable off. The reload and counter registers both read 0x8000. The interrupt and reset outputs are low.
- R2: Word index 0 (byte offset 0x00) is the control word. Its fields are: bits 15:8 prescale P, bit 5 run enable, bits 4:3 divider select, bit 2 interrupt enable, bit 0 reset enable. Every other bit reads as 0 and ignores writes.
- R3: Word index 1 (offset 0x04) is the 16-bit reload register. It reads back what was written in bits 15:0, and bits 31:16 read as 0.
- R4: While enabled, the counter decreases by one every (P+1)*2^(4+S) clocks, where S is the divider select.
- R5: While disabled, the counter holds its value and both dividers stay cleared. After enabling, the first decrement comes exactly one full tick period after the clock edge that set the enable bit.
- R6: Writing word index 2 (offset 0x08) loads the counter with bits 15:0 at that clock edge. This takes priority over a tick in the same cycle, and it is the keep-alive operation.
- R7: A tick that finds the counter at 1 or 0 is an expiry. On that same edge the counter takes the reload value.
- R8: On expiry with interrupt enable set, the interrupt output is high for exactly one cycle, in the cycle after the expiring tick. With interrupt enable clear, the interrupt output stays low.
- R9: On expiry with reset enable set, the reset output goes high in the cycle after the expiring tick and stays high for exactly 16 clocks. With reset enable clear, no reset pulse starts.
- R10: Word index 3 (offset 0x0C) is unmapped: it reads as 0 and writes to it change nothing. The two low address bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_o | output | 1 | One-cycle expiry interrupt |
| sysrst_o | output | 1 | Stretched system reset request |

## Verification
The assertions check on every cycle that the counter only moves in the allowed ways. While disabled it holds and no tick is produced. On a tick it drops by one, on a counter write it loads the written value, and on expiry it takes the reload value. They also check that the interrupt is a lone pulse that follows a tick, and that each reset pulse lasts exactly 16 clocks counted from its most recent expiry. The exact tick period for a given prescale and divider setting, the placement of the first tick after enabling, keep-alive sequences that prevent expiry, and the register field masks are shown only by the bench scenarios. The bench's timed reference model covers these.

// File: rtl/wdog_pkg.sv
// Package: shared field positions, widths, reset values and the control
// word type for the watchdog timer. Assumes a 16-bit control layout.
package wdog_pkg;
    localparam int PRE_W         = 8;   // prescale field width
    localparam int DIV_SEL_W     = 2;   // divider select width
    localparam int DIV_BASE_LOG2 = 4;   // smallest power-of-two divide (16)
    localparam int CTRL_W        = 16;  // visible control word width

    // Bit positions inside the control word (software decodes these)
    localparam int B_RE  = 0;
    localparam int B_IE  = 2;
    localparam int B_DIV = 3;
    localparam int B_EN  = 5;
    localparam int B_PRE = 8;

    // Word indices on the bus (byte address bits above the low two)
    localparam logic [1:0] IDX_CTRL   = 2'd0;
    localparam logic [1:0] IDX_RELOAD = 2'd1;
    localparam logic [1:0] IDX_COUNT  = 2'd2;

    typedef struct packed {
        logic [PRE_W-1:0]     pre;
        logic                 en;
        logic [DIV_SEL_W-1:0] div;
        logic                 ie;
        logic                 re;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{pre: 8'h80, en: 1'b0, div: 2'd3,
                                   ie: 1'b0, re: 1'b1};
endpackage

// File: rtl/wdog_tick_gen.sv
// Tick generator: divide-by-(P+1) prescaler followed by a selectable
// power-of-two divider. Emits a one-cycle tick at the end of each period.
// Assumes the settings are changed only while run is low; both counters
// are held cleared whenever run is low.
module wdog_tick_gen #(
    parameter int PRE_W         = 8,
    parameter int DIV_SEL_W     = 2,
    parameter int DIV_BASE_LOG2 = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [PRE_W-1:0]     pre_val,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);
    localparam int NSEL  = 1 << DIV_SEL_W;
    localparam int DIV_W = DIV_BASE_LOG2 + NSEL - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] lim_tab [NSEL];
    logic [DIV_W-1:0] div_lim;
    logic             pre_wrap;
    logic             div_last;

    // One terminal count per divider setting
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign lim_tab[g] = DIV_W'((1 << (DIV_BASE_LOG2 + g)) - 1);
    end

    // Select the terminal count and detect the end of both stages
    always_comb begin
        div_lim  = lim_tab[div_sel];
        pre_wrap = (pre_cnt >= pre_val);
        div_last = (div_cnt >= div_lim);
        tick     = run && pre_wrap && div_last;
    end

    // Advance the two-stage divider while running, clear it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            div_cnt <= div_last ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_regs.sv
// Register file and live counter: control word, reload value and the
// down-counter, with single-cycle writes and combinational reads.
// Assumes bus_wdata is at least CTRL_W bits wide. A counter write wins
// over a tick in the same cycle.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              tick,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic [CNT_W-1:0]  count_q,
    output logic              cnt_wr,
    output logic              expire,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(1) << (CNT_W - 1);

    logic [IDX_W-1:0]  idx;
    logic              hit_ctrl, hit_rel, hit_cnt;
    logic              ctrl_wr, rel_wr, at_end;
    logic [CTRL_W-1:0] ctrl_word;
    logic              unused_bits;

    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CTRL_W]};

    // Decode the word index and the write strobes
    always_comb begin
        idx      = bus_addr[ADDR_W-1:2];
        hit_ctrl = (idx == IDX_W'(IDX_CTRL));
        hit_rel  = (idx == IDX_W'(IDX_RELOAD));
        hit_cnt  = (idx == IDX_W'(IDX_COUNT));
        ctrl_wr  = bus_sel && bus_wr && hit_ctrl;
        rel_wr   = bus_sel && bus_wr && hit_rel;
        cnt_wr   = bus_sel && bus_wr && hit_cnt;
        at_end   = (count_q <= CNT_W'(1));
        expire   = tick && !cnt_wr && at_end;
    end

    // Control word storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (ctrl_wr) begin
            ctrl_q.pre <= bus_wdata[B_PRE +: PRE_W];
            ctrl_q.en  <= bus_wdata[B_EN];
            ctrl_q.div <= bus_wdata[B_DIV +: DIV_SEL_W];
            ctrl_q.ie  <= bus_wdata[B_IE];
            ctrl_q.re  <= bus_wdata[B_RE];
        end
    end

    // Reload value storage
    always_ff @(posedge clk) begin
        if (!rst_n)      reload_q <= CNT_RST;
        else if (rel_wr) reload_q <= bus_wdata[CNT_W-1:0];
    end

    // Live counter: load on write, reload on expiry, else count down on tick
    always_ff @(posedge clk) begin
        if (!rst_n)      count_q <= CNT_RST;
        else if (cnt_wr) count_q <= bus_wdata[CNT_W-1:0];
        else if (tick)   count_q <= at_end ? reload_q : count_q - 1'b1;
    end

    // Pack the control fields back into their bit positions
    always_comb begin
        ctrl_word                        = '0;
        ctrl_word[B_PRE +: PRE_W]        = ctrl_q.pre;
        ctrl_word[B_EN]                  = ctrl_q.en;
        ctrl_word[B_DIV +: DIV_SEL_W]    = ctrl_q.div;
        ctrl_word[B_IE]                  = ctrl_q.ie;
        ctrl_word[B_RE]                  = ctrl_q.re;
    end

    // Read multiplexer; the unmapped index returns zero
    always_comb begin
        if (hit_ctrl)     bus_rdata = DATA_W'(ctrl_word);
        else if (hit_rel) bus_rdata = DATA_W'(reload_q);
        else if (hit_cnt) bus_rdata = DATA_W'(count_q);
        else              bus_rdata = '0;
    end
endmodule

// File: rtl/wdog_expiry.sv
// Expiry outputs: a registered one-cycle interrupt and a reset request
// stretched to RST_CYCLES clocks. A new expiry restarts the stretch.
// Assumes expire is a single-cycle strobe.
module wdog_expiry #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic irq_en,
    input  logic rst_en,
    output logic irq_o,
    output logic sysrst_o
);
    localparam int RCW = $clog2(RST_CYCLES + 1);

    logic [RCW-1:0] rst_left;

    // Interrupt pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= expire && irq_en;
    end

    // Reset stretch counter
    always_ff @(posedge clk) begin
        if (!rst_n)                  rst_left <= '0;
        else if (expire && rst_en)   rst_left <= RCW'(RST_CYCLES);
        else if (rst_left != '0)     rst_left <= rst_left - 1'b1;
    end

    assign sysrst_o = (rst_left != '0);
endmodule

// File: rtl/wdog_timer.sv
// Top level of the watchdog timer: joins the register file, the tick
// chain and the expiry outputs. Assumes a single clock domain and a
// synchronous active-low reset.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 32,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              sysrst_o
);
    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  count_q;
    logic              tick;
    logic              cnt_wr;
    logic              expire;

    wdog_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tick(tick),
        .ctrl_q(ctrl_q), .reload_q(reload_q), .count_q(count_q),
        .cnt_wr(cnt_wr), .expire(expire), .bus_rdata(bus_rdata)
    );

    wdog_tick_gen #(.PRE_W(PRE_W), .DIV_SEL_W(DIV_SEL_W),
                    .DIV_BASE_LOG2(DIV_BASE_LOG2)) tick_i (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q.en), .pre_val(ctrl_q.pre),
        .div_sel(ctrl_q.div), .tick(tick)
    );

    wdog_expiry #(.RST_CYCLES(RST_CYCLES)) exp_i (
        .clk(clk), .rst_n(rst_n), .expire(expire), .irq_en(ctrl_q.ie),
        .rst_en(ctrl_q.re), .irq_o(irq_o), .sysrst_o(sysrst_o)
    );
endmodule

// File: rtl/wdog_timer_chk.sv
// Checker for the watchdog timer: temporal properties on the counter and
// the expiry outputs, bound into wdog_timer below.
module wdog_timer_chk #(
    parameter int CNT_W      = 16,
    parameter int RST_CYCLES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             ie,
    input logic             re,
    input logic             tick,
    input logic             expire,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] wr_val,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload,
    input logic             irq_o,
    input logic             sysrst_o
);
    localparam int AGE_W = $clog2(RST_CYCLES + 2);

    logic [AGE_W-1:0] age;

    // Clocks of reset output seen since the most recent reset-raising expiry
    always_ff @(posedge clk) begin
        if (!rst_n)              age <= '0;
        else if (expire && re)   age <= '0;
        else if (sysrst_o)       age <= age + 1'b1;
    end

    AST_NO_TICK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !tick);                                             // R5
    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cnt_wr) |=> $stable(count));                       // R5
    AST_DEC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && count > CNT_W'(1)) |=> (count == $past(count) - 1'b1)); // R4
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (count == $past(wr_val)));                       // R6
    AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == $past(reload)));                       // R7
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);                                          // R8
    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(tick && ie));                               // R8
    AST_RST_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        sysrst_o |-> (age < AGE_W'(RST_CYCLES)));                   // R9
    AST_RST_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sysrst_o) |-> (age == AGE_W'(RST_CYCLES)));           // R9
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) chk_i (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .ie(ctrl_q.ie), .re(ctrl_q.re),
    .tick(tick), .expire(expire), .cnt_wr(cnt_wr),
    .wr_val(bus_wdata[CNT_W-1:0]), .count(count_q), .reload(reload_q),
    .irq_o(irq_o), .sysrst_o(sysrst_o)
);

// File: tb/wdog_timer_tb_top.sv
// Bench for wdog_timer: a timed behavioural model compared on every clock,
// plus directed scenarios with hand-computed expectations.
module wdog_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h8;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        sysrst_o;

    int n_chk = 0, n_fail = 0;
    int m_ctrl, m_rel, m_cnt, m_ph, m_rc;
    bit m_irq;
    int irq_seen = 0, runs = 0, run = 0, last_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sysrst_o(sysrst_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reference model: clock count since enable, period from the fields
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 32'h8019; m_rel = 32'h8000; m_cnt = 32'h8000;
            m_ph = 0; m_irq = 0; m_rc = 0;
        end else begin
            bit en, tk, cw, ex, wr;
            int per;
            en  = m_ctrl[5];
            per = (((m_ctrl >> 8) & 255) + 1) * (16 << ((m_ctrl >> 3) & 3));
            tk  = en && (m_ph == per - 1);
            wr  = bus_sel && bus_wr;
            cw  = wr && (bus_addr[3:2] == 2'd2);
            ex  = tk && !cw && (m_cnt <= 1);
            m_irq = ex && m_ctrl[2];
            if (ex && m_ctrl[0]) m_rc = 16;
            else if (m_rc > 0)   m_rc = m_rc - 1;
            if (cw)      m_cnt = bus_wdata & 32'hFFFF;
            else if (tk) m_cnt = (m_cnt <= 1) ? m_rel : m_cnt - 1;
            m_ph = en ? (tk ? 0 : m_ph + 1) : 0;
            if (wr && bus_addr[3:2] == 2'd0) m_ctrl = bus_wdata & 32'hFF3D;
            if (wr && bus_addr[3:2] == 2'd1) m_rel  = bus_wdata & 32'hFFFF;
        end
    end

    // Every-clock comparison of outputs against the model
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            case (bus_addr[3:2])
                2'd0:    chk("R2 ctrl vs model", bus_rdata, m_ctrl);
                2'd1:    chk("R3 reload vs model", bus_rdata, m_rel);
                2'd2:    chk("R4/R6/R7 count vs model", bus_rdata, m_cnt);
                default: chk("R10 unmapped vs model", bus_rdata, 0);
            endcase
            chk("R8 irq vs model", int'(irq_o), int'(m_irq));
            chk("R9 sysrst vs model", int'(sysrst_o), int'(m_rc != 0));
        end
    end

    // Pulse monitor for interrupts and reset runs
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_o) irq_seen++;
            if (sysrst_o) run++;
            else if (run > 0) begin last_run = run; runs++; run = 0; end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h8;
    endtask

    task automatic rd(input logic [3:0] a, input int exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        n_fail++;
        $display("FAIL WDOG timeout: got 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        int i0, r0, v1;
        wait_cyc(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'h0, 32'h8019, "R1 ctrl reset");
        rd(4'h4, 32'h8000, "R1 reload reset");
        rd(4'h8, 32'h8000, "R1 count reset");
        chk("R1 irq reset", int'(irq_o), 0);
        chk("R1 sysrst reset", int'(sysrst_o), 0);
        // R2 field masks
        wr(4'h0, 32'hFFFF_FFDF);
        rd(4'h0, 32'h0000_FF1D, "R2 ctrl mask");
        wr(4'h0, 32'h0000_0042);
        rd(4'h0, 32'h0, "R2 reserved bits");
        // R3 reload width
        wr(4'h4, 32'hFFFF_1234);
        rd(4'h4, 32'h1234, "R3 reload readback");
        // R10 unmapped
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, 0, "R10 unmapped read");
        rd(4'h0, 0, "R10 ctrl untouched");
        rd(4'h4, 32'h1234, "R10 reload untouched");
        // R6 load while disabled, R5 hold
        wr(4'h8, 32'h5);
        rd(4'h8, 5, "R6 counter load");
        wait_cyc(40);
        rd(4'h8, 5, "R5 hold while off");
        // R4 exact period with P=0, S=3 (128 clocks)
        wr(4'h8, 32'h10);
        wr(4'h4, 32'h100);
        wr(4'h0, 32'h0038);
        wait_cyc(127);
        #1 chk("R5 first tick not early", bus_rdata, 32'h10);
        wait_cyc(1);
        #1 chk("R4 first tick at full period", bus_rdata, 32'h0F);
        wait_cyc(128);
        #1 chk("R4 second tick", bus_rdata, 32'h0E);
        wr(4'h0, 32'h0);
        // R8 interrupts with P=0, S=0 (16 clocks), reset disabled
        wr(4'h4, 32'h3);
        wr(4'h8, 32'h5);
        i0 = irq_seen; r0 = runs;
        wr(4'h0, 32'h0024);
        wait_cyc(185);
        chk("R8 irq pulse count", irq_seen - i0, 3);
        chk("R9 no reset when disabled", runs - r0, 0);
        wr(4'h0, 32'h0004);
        rd(4'h8, 3, "R7 reload after expiry");
        v1 = bus_rdata;
        wait_cyc(50);
        #1 chk("R5 hold after disable", bus_rdata, v1);
        // R9 reset pulse with P=2, S=1 (96 clocks)
        wr(4'h8, 32'h2);
        wr(4'h4, 32'h4);
        i0 = irq_seen; r0 = runs;
        wr(4'h0, 32'h0229);
        wait_cyc(230);
        chk("R9 one reset pulse", runs - r0, 1);
        chk("R9 reset pulse length", last_run, 16);
        chk("R8 no irq when disabled", irq_seen - i0, 0);
        wr(4'h0, 32'h0200);
        // R6 keep-alive prevents expiry
        i0 = irq_seen; r0 = runs;
        wr(4'h0, 32'h0025);
        for (int k = 0; k < 10; k++) begin
            wr(4'h8, 32'h3);
            wait_cyc(28);
        end
        chk("R6 keep-alive no irq", irq_seen - i0, 0);
        chk("R6 keep-alive no reset", runs - r0, 0);
        wait_cyc(60);
        chk("R8 irq after keep-alive stops", irq_seen - i0, 1);
        chk("R9 reset after keep-alive stops", runs - r0, 1);
        chk("R9 pulse length again", last_run, 16);
        wr(4'h0, 32'h0);
        // R7 counter at zero expires on next tick
        wr(4'h8, 32'h0);
        i0 = irq_seen;
        wr(4'h0, 32'h0024);
        wait_cyc(17);
        #1 chk("R7 zero count reloads", bus_rdata, 4);
        chk("R7 zero count raises irq", irq_seen - i0, 1);
        wr(4'h0, 32'h0);
        wait_cyc(5);
        summary();
        $finish;
    end
endmodule